// File: doc/BRIEF.md
# Reversible Compute-Copy-Uncompute Pipeline

This block computes two Boolean results from four data lines with a fixed network of reversible gates and leaves no garbage behind. Each vector passes through nine gate levels, and each level is one register stage. The first four levels are the forward cascade: a Toffoli gate, a Fredkin gate, a controlled-NOT and a second Toffoli gate. The fifth level uses two controlled-NOT gates to copy the two results onto two spy lines that enter at zero. The last four levels apply the forward gates again in reverse order. Every gate in the network is its own inverse, so these levels return the four data lines to their input values. At the output, the consumer receives the original vector unchanged on the data lines and the two results on the spy lines.

The block takes data through a valid/ready stream and gives data out through another. One vector can enter per cycle. The whole pipeline advances when the output is not holding a valid result or when the consumer takes it (`out_ready`). Otherwise every stage holds, and `in_ready` is low. `out_valid` marks the cycles in which the data lines hold the reconstructed inputs.

Top module: `rev_mirror_pipe`

## Requirements
- R1: After reset, `out_valid` is 0. It stays 0 until a vector has passed through all nine levels.
- R2: For every accepted vector, `out_data` equals the `in_data` of that vector. Bit 0 is line A, bit 1 is B, bit 2 is C and bit 3 is D.
- R3: `out_spy[0]` holds F1. F1 is computed as follows. Let c1 = C xor (A and B). If c1 is 1, B and D swap, giving b2 and d2. Then d3 = d2 xor A. F1 = c1 xor (b2 and d3).
- R4: `out_spy[1]` holds F2, which is d3 from R3.
- R5: When `out_ready` stays 1, a vector accepted on one clock edge appears with `out_valid` high 9 edges later. A new vector is accepted on every edge.
- R6: `in_ready` equals `out_ready or not out_valid`. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_spy` stay unchanged.
- R7: Both `in_spy` bits must be 0 whenever `in_valid` is 1. The spy lines then carry only the copied results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid flags |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Pipeline accepts on this edge |
| in_data | input | 4 | Data lines A (bit 0) to D (bit 3) |
| in_spy | input | 2 | Spy lines at entry, required to be zero |
| out_valid | output | 1 | Output holds reconstructed inputs and results |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | 4 | Reconstructed data lines |
| out_spy | output | 2 | Copied results, F1 in bit 0 and F2 in bit 1 |

## Verification
The assertions assume that the producer drives both spy lines low on every valid input. Reversibility only removes the garbage when the copy targets start at zero. The stimulus ties `in_spy` to zero for all vectors. The stimulus sends all sixteen data values, both back to back and under an irregular `out_ready` pattern. That pattern fills the pipeline, lowers `in_ready` and makes the output hold through stalls. The mirror-level assertions check that the copy level leaves the data lines alone and that the uncompute levels leave the spy lines alone.

// File: rtl/rev_pkg.sv
package rev_pkg;

  localparam int DATA_W     = 4;
  localparam int SPY_W      = 2;
  localparam int LINES      = DATA_W + SPY_W;
  localparam int FWD_LEVELS = 4;
  localparam int DEPTH      = 2 * FWD_LEVELS + 1;
  localparam int IDX_W      = $clog2(LINES);

  localparam int L_A  = 0;
  localparam int L_B  = 1;
  localparam int L_C  = 2;
  localparam int L_D  = 3;
  localparam int L_S1 = DATA_W;
  localparam int L_S2 = DATA_W + 1;

  typedef logic [LINES-1:0] lines_t;

  typedef enum logic [1:0] {
    G_TOF   = 2'd0,
    G_FRED  = 2'd1,
    G_CNOT  = 2'd2,
    G_COPY2 = 2'd3
  } gate_kind_e;

  // p0/p1/p2/p3 meaning per kind:
  //   TOF  : controls p0,p1, target p2
  //   FRED : control p0, swapped pair p1,p2
  //   CNOT : control p0, target p1
  //   COPY2: p0 -> p1 and p2 -> p3
  typedef struct packed {
    gate_kind_e       kind;
    logic [IDX_W-1:0] p0;
    logic [IDX_W-1:0] p1;
    logic [IDX_W-1:0] p2;
    logic [IDX_W-1:0] p3;
  } gate_t;

  function automatic gate_t mk(gate_kind_e k, int a, int b, int c, int d);
    gate_t g;
    g.kind = k;
    g.p0   = IDX_W'(a);
    g.p1   = IDX_W'(b);
    g.p2   = IDX_W'(c);
    g.p3   = IDX_W'(d);
    return g;
  endfunction

  function automatic gate_t fwd_gate(int k);
    case (k)
      0:       return mk(G_TOF,  L_A, L_B, L_C, 0);
      1:       return mk(G_FRED, L_C, L_B, L_D, 0);
      2:       return mk(G_CNOT, L_A, L_D, 0,   0);
      default: return mk(G_TOF,  L_B, L_D, L_C, 0);
    endcase
  endfunction

  // Mirror: level DEPTH-1-k repeats forward gate k.
  function automatic gate_t level_gate(int lvl);
    if (lvl < FWD_LEVELS)       return fwd_gate(lvl);
    else if (lvl == FWD_LEVELS) return mk(G_COPY2, L_C, L_S1, L_D, L_S2);
    else                        return fwd_gate(DEPTH - 1 - lvl);
  endfunction

endpackage

// File: rtl/rev_gate.sv
module rev_gate
  import rev_pkg::*;
#(
  parameter gate_t G = mk(G_CNOT, 0, 1, 0, 0)
) (
  input  lines_t din,
  output lines_t dout
);

  always_comb begin
    dout = din;
    case (G.kind)
      G_TOF:   dout[G.p2] = din[G.p2] ^ (din[G.p0] & din[G.p1]);
      G_FRED: begin
        if (din[G.p0]) begin
          dout[G.p1] = din[G.p2];
          dout[G.p2] = din[G.p1];
        end
      end
      G_CNOT:  dout[G.p1] = din[G.p1] ^ din[G.p0];
      default: begin
        dout[G.p1] = din[G.p1] ^ din[G.p0];
        dout[G.p3] = din[G.p3] ^ din[G.p2];
      end
    endcase
  end

endmodule

// File: rtl/rev_stage.sv
module rev_stage
  import rev_pkg::*;
#(
  parameter gate_t G = mk(G_CNOT, 0, 1, 0, 0)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  logic   in_vld,
  input  lines_t in_lines,
  output logic   out_vld,
  output lines_t out_lines
);

  lines_t gated;

  rev_gate #(.G(G)) i_gate (
    .din  (in_lines),
    .dout (gated)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   out_vld <= 1'b0;
    else if (adv) out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (adv) out_lines <= gated;
  end

  // R6
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && out_vld) |=> (out_vld && $stable(out_lines)));

endmodule

// File: rtl/rev_mirror_pipe.sv
module rev_mirror_pipe
  import rev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SPY_W-1:0]  in_spy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SPY_W-1:0]  out_spy
);

  lines_t line [DEPTH+1];
  logic   vld  [DEPTH+1];
  logic   adv;

  assign line[0] = {in_spy, in_data};
  assign vld[0]  = in_valid;
  assign adv     = out_ready || !vld[DEPTH];
  assign in_ready = adv;

  for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
    rev_stage #(.G(level_gate(k))) i_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .in_vld    (vld[k]),
      .in_lines  (line[k]),
      .out_vld   (vld[k+1]),
      .out_lines (line[k+1])
    );

    if (k > FWD_LEVELS) begin : g_mirror_chk
      // R3 R4: uncompute levels never disturb the copied results
      spy_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && vld[k]) |=>
          (line[k+1][LINES-1:DATA_W] == $past(line[k][LINES-1:DATA_W])));
    end else if (k == FWD_LEVELS) begin : g_copy_chk
      // R2: the copy level leaves the data lines as they were
      data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && vld[k]) |=>
          (line[k+1][DATA_W-1:0] == $past(line[k][DATA_W-1:0])));
    end
  end

  assign out_valid = vld[DEPTH];
  assign out_data  = line[DEPTH][DATA_W-1:0];
  assign out_spy   = line[DEPTH][LINES-1:DATA_W];

  // R7
  spy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_spy == '0));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_spy)));

endmodule

// File: tb/test_rev_mirror_pipe.sv
module test_rev_mirror_pipe;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [3:0] in_data, out_data;
  logic [1:0] in_spy, out_spy;

  int checks = 0;
  int errors = 0;
  int nticks = 0;
  bit lat_check = 1'b0;
  bit prev_hold = 1'b0;
  logic [5:0] prev_out;
  int q_tick[$];
  logic [3:0] q_data[$];

  always #5 clk = ~clk;

  rev_mirror_pipe i_rev_mirror_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_spy(in_spy),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_spy(out_spy)
  );

  function automatic logic [1:0] ref_f(input logic [3:0] v);
    int a = v[0], b = v[1], c = v[2], d = v[3], t;
    c = c ^ (a & b);
    if (c == 1) begin t = b; b = d; d = t; end
    d = d ^ a;
    c = c ^ (b & d);
    return {d[0], c[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic step(input bit iv, input logic [3:0] id, input bit ordy, output bit acc);
    logic [1:0] f;
    int t;
    logic [3:0] d;
    @(negedge clk);
    in_valid  = iv;
    in_data   = id;
    in_spy    = 2'b00;
    out_ready = ordy;
    #4;
    nticks++;
    if (nticks > 20000) begin
      chk(1'b0, "watchdog", nticks, 20000);
      finish_run();
    end
    if (prev_hold)
      chk({out_data, out_spy} == prev_out, "R6 hold", {out_data, out_spy}, prev_out);
    chk(in_ready == (out_ready || !out_valid), "R6 ready", in_ready, out_ready || !out_valid);
    if (out_valid && out_ready) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R2 unexpected output", 1, 0);
      end else begin
        t = q_tick.pop_front();
        d = q_data.pop_front();
        f = ref_f(d);
        chk(out_data == d, "R2 restore", out_data, d);
        chk(out_spy[0] == f[0], "R3 F1 (spy entered as 0, R7)", out_spy[0], f[0]);
        chk(out_spy[1] == f[1], "R4 F2", out_spy[1], f[1]);
        if (lat_check) chk(nticks - t == 9, "R5 latency", nticks - t, 9);
      end
    end
    acc = in_valid && in_ready;
    if (acc) begin
      q_tick.push_back(nticks);
      q_data.push_back(in_data);
    end
    prev_hold = out_valid && !out_ready;
    prev_out  = {out_data, out_spy};
  endtask

  initial begin
    bit acc;
    int idx;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_spy = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #4;
    chk(out_valid == 1'b0, "R1 reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 4'd0, 1'b1, acc);
    chk(out_valid == 1'b0, "R1 idle", out_valid, 0);

    // back to back, all sixteen vectors
    lat_check = 1'b1;
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 4'(v), 1'b1, acc);
      chk(acc, "R5 throughput", acc, 1);
    end
    for (int i = 0; i < 12; i++) step(1'b0, 4'd0, 1'b1, acc);
    chk(q_data.size() == 0, "R2 drained", q_data.size(), 0);
    lat_check = 1'b0;

    // fill while the consumer stalls
    for (int i = 0; i < 14; i++) step(1'b1, 4'(i + 3), 1'b0, acc);
    chk(in_ready == 1'b0, "R6 full stall", in_ready, 0);
    chk(out_valid == 1'b1, "R6 full valid", out_valid, 1);

    // irregular back-pressure
    idx = 0;
    for (int i = 0; i < 200 && idx < 32; i++) begin
      step(1'b1, 4'(idx), ((i * 7) % 5) != 0, acc);
      if (acc) idx++;
    end
    for (int i = 0; i < 30; i++) step(1'b0, 4'd0, 1'b1, acc);
    chk(q_data.size() == 0, "R2 drained after stalls", q_data.size(), 0);
    chk(out_valid == 1'b0, "R1 empty again", out_valid, 0);
    finish_run();
  end

endmodule